// File: doc/BRIEF.md
# Prescaled Timer with Overflow Interrupt

This block is a counter that runs 8 or 16 bits wide. An input `tick` advances it, either on every tick or once per 2^(n+1) ticks through a hidden 8-bit divider that sits in front of it. Software reaches the block through a small register port with four addresses: the counter low byte, the counter high byte, a control byte and a flag byte. When the counter wraps to zero it sets a sticky overflow flag, and this flag drives `irq` whenever the interrupt enable bit is set.

Writing the low byte loads the counter. When the divider is in use, the same write clears the divider count, so the next increment comes a full period later. In 16-bit mode the high byte is buffered in both directions. A low-byte read captures the high byte, so that the value read next is coherent with it. A high-byte write is held in a buffer and reaches the counter together with the next low-byte write. Software may change the divider ratio or bypass it while the counter runs.

Top module: `tmr_prescaled_timer`

## Requirements
- R1: After reset the counter is 0, the control byte is 0 (stopped, 8-bit, divider in use, ratio code 0, interrupt disabled), the flag is 0 and `irq` is 0.
- R2: Control byte at address 2: bit 0 run, bit 1 16-bit mode, bit 2 divider bypass, bits 5:3 ratio code, bit 6 interrupt enable. It reads back as written, with bit 7 read as 0.
- R3: With run=1 and bypass=1, the counter increments once for each cycle in which `tick` is 1, and the divider count is left untouched.
- R4: With run=1 and bypass=0, the counter increments on every 2^(code+1)-th tick (code 0 gives 2 and code 7 gives 256). A change of code or bypass takes effect from the next tick, with no reset of the divider count.
- R5: With run=0, ticks have no effect. The counter and the divider count both hold.
- R6: Writing the low byte (address 0) loads the counter and, when bypass=0, clears the divider count. The write takes priority over an increment in the same cycle, and it leaves the control byte unchanged.
- R7: In 8-bit mode the low byte counts, and the high byte keeps its value. A step from FFh to 00h sets the flag.
- R8: In 16-bit mode a step from FFFFh to 0000h sets the flag. A low byte that wraps on its own (00FFh to 0100h) does not set it.
- R9: The flag (address 3, bit 0) stays set until software writes address 3 with bit 0 = 1. When an overflow and such a clear fall in the same cycle, the flag stays set.
- R10: `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R11: In 16-bit mode a read of address 0 (with `rd_en`) captures the high byte, and later reads of address 1 return the captured value. A write of address 1 goes to a buffer that the next write of address 0 loads into the counter. In 8-bit mode address 1 reads the counter high byte directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count event, one per cycle at most |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on address 0) |
| addr | input | 2 | Register address: 0 low, 1 high, 2 control, 3 flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A write, a tick or a low-byte read acts at the clock edge it is presented to. The counter, the divider, the flag, the buffers and `irq` therefore all show the result one edge later, and `rdata` follows the address with no delay. The bench drives a stimulus just after a falling edge and lets the next rising edge update both the design and a behavioural model. It then compares `rdata` and `irq` with the model 2 ns after the following falling edge, which is within one cycle of the stimulus. Divider periods of up to 256 ticks are checked cycle by cycle, so an increment that comes one tick early or late is a mismatch.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int TMR_SEL_W = 3;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_CTRL = 2'd2,
        REG_FLAG = 2'd3
    } reg_addr_e;

    // Packed from MSB: bit 6 irq_en, 5:3 ratio, 2 bypass, 1 wide, 0 run
    typedef struct packed {
        logic                 irq_en;
        logic [TMR_SEL_W-1:0] ratio;
        logic                 bypass;
        logic                 wide;
        logic                 run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
    parameter int SEL_W = tmr_pkg::TMR_SEL_W,
    localparam int PSC_W = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    logic [PSC_W-1:0] cnt;
    logic [PSC_W-1:0] term;

    // term[k] marks the last tick of a 2^(k+1) period
    for (genvar k = 0; k < PSC_W; k++) begin : g_term
        assign term[k] = &cnt[k:0];
    end

    assign pulse = step && term[sel];

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end

    // R6
    psc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
    // R5
    psc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wide,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic at_top;
    assign at_top = wide ? (&cnt) : (&cnt[BYTE_W-1:0]);
    assign ovf    = inc && !load && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            if (wide) cnt <= cnt + 1'b1;
            else      cnt[BYTE_W-1:0] <= cnt[BYTE_W-1:0] + 1'b1;
        end
    end

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt[BYTE_W-1:0] == '0));
    // R7
    narrow_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!wide && !load) |=> (cnt[CNT_W-1:BYTE_W] == $past(cnt[CNT_W-1:BYTE_W])));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_addr_e         addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf,
    output ctrl_t             ctrl,
    output logic [BYTE_W-1:0] hi_buf,
    output logic              flag,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] hi_lat;
    logic              clr_req;

    assign clr_req = wr_en && (addr == REG_FLAG) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            hi_buf <= '0;
            hi_lat <= '0;
            flag   <= 1'b0;
        end else begin
            if (wr_en && addr == REG_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_en && addr == REG_HI)   hi_buf <= wdata;
            if (rd_en && addr == REG_LO)   hi_lat <= cnt[CNT_W-1:BYTE_W];
            if (ovf)          flag <= 1'b1;
            else if (clr_req) flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            REG_LO:   rdata = cnt[BYTE_W-1:0];
            REG_HI:   rdata = ctrl.wide ? hi_lat : cnt[CNT_W-1:BYTE_W];
            REG_CTRL: rdata = BYTE_W'(ctrl);
            REG_FLAG: rdata = BYTE_W'(flag);
            default:  rdata = '0;
        endcase
    end

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flag);
    // R11
    hi_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == REG_LO) |=> (hi_lat == $past(cnt[CNT_W-1:BYTE_W])));
endmodule

// File: rtl/tmr_prescaled_timer.sv
`timescale 1ns/1ps
module tmr_prescaled_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [BYTE_W-1:0] hi_buf;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  load_val;
    logic              flag, ovf, wr_lo, step, psc_pulse, inc;
    reg_addr_e         raddr;

    assign raddr    = reg_addr_e'(addr);
    assign wr_lo    = wr_en && (raddr == REG_LO);
    assign step     = ctrl.run && tick && !ctrl.bypass;
    assign inc      = (ctrl.run && tick && ctrl.bypass) || psc_pulse;
    assign load_val = ctrl.wide ? {hi_buf, wdata} : {cnt[CNT_W-1:BYTE_W], wdata};
    assign irq      = flag && ctrl.irq_en;

    tmr_prescaler #(.SEL_W(TMR_SEL_W)) u_psc (
        .clk(clk), .rst(rst), .step(step), .clr(wr_lo && !ctrl.bypass),
        .sel(ctrl.ratio), .pulse(psc_pulse)
    );

    tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(inc), .wide(ctrl.wide), .load(wr_lo),
        .load_val(load_val), .cnt(cnt), .ovf(ovf)
    );

    tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(raddr),
        .wdata(wdata), .cnt(cnt), .ovf(ovf), .ctrl(ctrl), .hi_buf(hi_buf),
        .flag(flag), .rdata(rdata)
    );

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !wr_lo) |=> $stable(cnt));
    // R8
    no_early_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag && !ovf) |=> !flag);
endmodule

// File: tb/tmr_prescaled_timer_test.sv
`timescale 1ns/1ps
module tmr_prescaled_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0, fails = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_cnt, m_psc, m_ctrl, m_flag, m_hibuf, m_hilat;

    always #10 clk = ~clk;

    tmr_prescaled_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) begin
        int run, wide, byp, ratio, inc, ovf, mask, npsc;
        if (rst) begin
            m_cnt = 0; m_psc = 0; m_ctrl = 0; m_flag = 0; m_hibuf = 0; m_hilat = 0;
        end else begin
            run = m_ctrl & 1; wide = (m_ctrl >> 1) & 1; byp = (m_ctrl >> 2) & 1;
            ratio = (m_ctrl >> 3) & 7;
            inc = 0; ovf = 0; npsc = m_psc;
            if (run != 0 && tick) begin
                if (byp != 0) inc = 1;
                else begin
                    mask = (2 << ratio) - 1;
                    if ((m_psc & mask) == mask) inc = 1;
                    npsc = (m_psc + 1) & 255;
                end
            end
            if (wr_en && addr == 2'd0 && byp == 0) npsc = 0;
            if (rd_en && addr == 2'd0) m_hilat = (m_cnt >> 8) & 255;
            if (wr_en && addr == 2'd0) begin
                if (wide != 0) m_cnt = m_hibuf * 256 + wdata;
                else           m_cnt = (m_cnt & 16'hFF00) | wdata;
            end else if (inc != 0) begin
                if (wide != 0) begin
                    if (m_cnt == 65535) begin m_cnt = 0; ovf = 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if ((m_cnt & 255) == 255) begin m_cnt = m_cnt & 16'hFF00; ovf = 1; end
                    else m_cnt = m_cnt + 1;
                end
            end
            m_psc = npsc;
            if (wr_en && addr == 2'd1) m_hibuf = wdata;
            if (wr_en && addr == 2'd2) m_ctrl = wdata & 127;
            if (ovf != 0) m_flag = 1;
            else if (wr_en && addr == 2'd3 && wdata[0]) m_flag = 0;
        end
    end

    function automatic int exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt & 255;
            2'd1:    return (((m_ctrl >> 1) & 1) != 0) ? m_hilat : ((m_cnt >> 8) & 255);
            2'd2:    return m_ctrl;
            default: return m_flag;
        endcase
    endfunction

    task automatic cyc(input bit t, input bit w, input bit r, input logic [1:0] a,
                       input logic [7:0] d);
        int er, ei;
        @(negedge clk);
        tick = t; wr_en = w; rd_en = r; addr = a; wdata = d;
        #2;
        er = exp_rdata(a);
        ei = ((m_flag != 0) && (((m_ctrl >> 6) & 1) != 0)) ? 1 : 0;
        checks++;
        if (int'(rdata) != er) begin
            fails++;
            $display("FAIL %s rdata addr=%0d actual=%0h expected=%0h at %0t",
                     cur_req, a, rdata, er, $time);
        end
        checks++;
        if (int'(irq) != ei) begin
            fails++;
            $display("FAIL %s irq actual=%0d expected=%0d at %0t", cur_req, irq, ei, $time);
        end
    endtask

    task automatic ticks(input int n, input logic [1:0] a);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, a, 8'h00);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b0, a, d);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state on every address
        cur_req = "R1";
        for (int a = 0; a < 4; a++) cyc(1'b0, 1'b0, 1'b0, 2'(a), 8'h00);

        // R2: control byte read-back
        cur_req = "R2";
        wr(2'd2, 8'hFA);
        cyc(1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
        wr(2'd2, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 2'd2, 8'h00);

        // R3: bypass, one step per tick
        cur_req = "R3";
        wr(2'd2, 8'h05);
        ticks(10, 2'd0);
        for (int i = 0; i < 12; i++) cyc(1'(i % 2), 1'b0, 1'b0, 2'd0, 8'h00);

        // R5: stopped, ticks ignored
        cur_req = "R5";
        wr(2'd2, 8'h04);
        ticks(8, 2'd0);
        wr(2'd2, 8'h09);
        ticks(3, 2'd0);
        wr(2'd2, 8'h08);
        ticks(9, 2'd0);
        wr(2'd2, 8'h09);
        ticks(6, 2'd0);

        // R4: every ratio code, then on-the-fly change
        cur_req = "R4";
        for (int c = 0; c < 8; c++) begin
            wr(2'd2, 8'(1 | (c << 3)));
            wr(2'd0, 8'h00);
            ticks(3 * (2 << c) + 1, 2'd0);
            cyc(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        end
        wr(2'd2, 8'h11);
        ticks(5, 2'd0);
        wr(2'd2, 8'h01);
        ticks(5, 2'd0);
        wr(2'd2, 8'h05);
        ticks(3, 2'd0);
        wr(2'd2, 8'h19);
        ticks(20, 2'd0);

        // R6: load clears divider, wins over increment, control kept
        cur_req = "R6";
        wr(2'd2, 8'h11);
        ticks(6, 2'd0);
        cyc(1'b1, 1'b1, 1'b0, 2'd0, 8'h40);
        ticks(10, 2'd0);
        cyc(1'b0, 1'b0, 1'b0, 2'd2, 8'h00);
        wr(2'd2, 8'h15);
        ticks(3, 2'd0);
        cyc(1'b1, 1'b1, 1'b0, 2'd0, 8'h50);
        wr(2'd2, 8'h11);
        ticks(10, 2'd0);

        // R7: 8-bit wrap, high byte kept
        cur_req = "R7";
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h12);
        wr(2'd0, 8'hFD);
        ticks(5, 2'd0);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);

        // R9: clear, ignored clear, set-wins
        cur_req = "R9";
        wr(2'd3, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);
        wr(2'd3, 8'h01);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);
        wr(2'd0, 8'hFF);
        cyc(1'b1, 1'b1, 1'b0, 2'd3, 8'h01);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);
        wr(2'd3, 8'h01);

        // R8: 16-bit wrap only from FFFF
        cur_req = "R8";
        wr(2'd2, 8'h07);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFE);
        ticks(3, 2'd3);
        cyc(1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFD);
        ticks(4, 2'd3);

        // R10: interrupt gating
        cur_req = "R10";
        wr(2'd2, 8'h46);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);
        wr(2'd2, 8'h06);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);
        wr(2'd2, 8'h46);
        wr(2'd3, 8'h01);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 8'h00);

        // R11: coherent high-byte access
        cur_req = "R11";
        wr(2'd2, 8'h06);
        wr(2'd1, 8'hAB);
        cyc(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
        wr(2'd0, 8'hCD);
        cyc(1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
        wr(2'd1, 8'h11);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 8'h00);
        wr(2'd2, 8'h07);
        wr(2'd1, 8'h20);
        wr(2'd0, 8'hFE);
        cyc(1'b1, 1'b0, 1'b1, 2'd0, 8'h00);
        ticks(2, 2'd1);
        cyc(1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 8'h00);
        wr(2'd2, 8'h05);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule